// File: doc/BRIEF.md
# Wordclock Reference Selector and Feedback Divider

This block sets up the two clock inputs of a digital-audio phase-locked loop. Software writes an 8-bit control register. The register chooses one of four candidate wordclocks: two derived from crystal oscillators and two from external inputs. The chosen clock, halved when it arrives at double speed, becomes the reference for the phase-frequency detector. The block also divides the high-speed VCO clock down to a single-speed feedback wordclock, by 2^FB_DIV_LOG2 or by half that. In lock, the VCO therefore runs at 512 or 256 times the reference rate with the default setting. The oscillators and the detector are outside the block.

The active source is held as a four-state machine. Its states are ST_XTAL1, ST_XTAL2, ST_EXT_A and ST_EXT_B. Reset enters ST_XTAL1. The only transition is "write": on any clock edge where `wr_en` is high, the machine moves from whatever state it is in to the state coded by `wr_data[1:0]`. Without a write it stays where it is. The output decoder raises `xtal_en` in the two crystal states and lowers it in the two external states, which switches both crystal oscillators off. The reference inputs are sampled in the system clock domain. Source switching is not glitch-free.

Top module: `wordclock_ref_sel`

## Requirements
- R1: After reset the register reads as zero. This selects crystal 1 with `xtal_en` high, no halving, and feedback division by 2^FB_DIV_LOG2. `pfd_ref` and `fb_wc` are low.
- R2: With `wr_data[2]`=0 written, `pfd_ref` follows the input selected by `wr_data[1:0]` (0 crystal 1, 1 crystal 2, 2 external A, 3 external B), one system clock edge after that input changes. The unselected inputs have no effect.
- R3: `xtal_en` is high when the stored source code is 0 or 1 and low when it is 2 or 3. It changes at the clock edge that performs the write.
- R4: With `wr_data[2]`=1 written, `pfd_ref` toggles once for each rising edge of the selected input, two clock edges after that edge. At no other time does it change.
- R5: Bits 7 to 4 of `wr_data` have no effect on any output.
- R6: With `wr_data[3]`=0, `fb_wc` has a period of 2^FB_DIV_LOG2 VCO cycles. With `wr_data[3]`=1 the period is 2^(FB_DIV_LOG2-1) cycles. In both cases `fb_wc` is high for the second half of each period, counted from reset.
- R7: When `wr_en` is low, `wr_data` is ignored and the configuration holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control value: [1:0] source, [2] halve, [3] short feedback ratio, [7:4] reserved |
| xtal1_wc | input | 1 | Crystal 1 wordclock |
| xtal2_wc | input | 1 | Crystal 2 wordclock |
| ext_a_wc | input | 1 | External wordclock A |
| ext_b_wc | input | 1 | External wordclock B |
| vco_clk | input | 1 | VCO clock to divide |
| pfd_ref | output | 1 | Reference wordclock to the phase detector |
| fb_wc | output | 1 | Divided VCO feedback wordclock |
| xtal_en | output | 1 | Crystal oscillator enable |

## Verification
The bench builds the block with FB_DIV_LOG2 set to 4, in place of the default 9. The full ratio is then 16 VCO cycles and the short ratio 8. This brings both feedback ratios, and the exact edge where `fb_wc` rises and falls, within reach of a few dozen gated VCO pulses. All four source codes and both reference modes are covered with short directed pulse trains.

// File: rtl/wcsel_pkg.sv
package wcsel_pkg;
    localparam int CTRL_W   = 8;
    localparam int SEL_W    = 2;
    localparam int BIT_HALVE = 2;
    localparam int BIT_SHORT = 3;
    localparam int USED_W   = 4;

    typedef enum logic [SEL_W-1:0] {
        ST_XTAL1 = 2'd0,
        ST_XTAL2 = 2'd1,
        ST_EXT_A = 2'd2,
        ST_EXT_B = 2'd3
    } src_e;
endpackage

// File: rtl/wcsel_ctrl.sv
module wcsel_ctrl
    import wcsel_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [USED_W-1:0]   wr_bits,
    output src_e                src,
    output logic                halve_en,
    output logic                fb_short,
    output logic                xtal_en
);
    src_e src_q, src_d;
    logic halve_q, short_q;

    // next-state: the single "write" transition
    always_comb begin
        src_d = src_q;
        if (wr_en) begin
            unique case (wr_bits[SEL_W-1:0])
                2'd0: src_d = ST_XTAL1;
                2'd1: src_d = ST_XTAL2;
                2'd2: src_d = ST_EXT_A;
                2'd3: src_d = ST_EXT_B;
                default: src_d = ST_XTAL1;
            endcase
        end
    end

    // state register and mode bits
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q   <= ST_XTAL1;
            halve_q <= 1'b0;
            short_q <= 1'b0;
        end else begin
            src_q <= src_d;
            if (wr_en) begin
                halve_q <= wr_bits[BIT_HALVE];
                short_q <= wr_bits[BIT_SHORT];
            end
        end
    end

    // outputs decoded from state
    always_comb begin
        unique case (src_q)
            ST_XTAL1, ST_XTAL2: xtal_en = 1'b1;
            ST_EXT_A, ST_EXT_B: xtal_en = 1'b0;
            default:            xtal_en = 1'b1;
        endcase
    end

    assign src      = src_q;
    assign halve_en = halve_q;
    assign fb_short = short_q;
endmodule

// File: rtl/wcsel_ref_path.sv
module wcsel_ref_path (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_raw,
    input  logic halve_en,
    output logic ref_out,
    output logic ref_rise
);
    logic ref_q, ref_prev, half_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_q    <= 1'b0;
            ref_prev <= 1'b0;
            half_q   <= 1'b0;
        end else begin
            ref_q    <= ref_raw;
            ref_prev <= ref_q;
            if (ref_rise) half_q <= ~half_q;
        end
    end

    assign ref_rise = ref_q & ~ref_prev;
    assign ref_out  = halve_en ? half_q : ref_q;
endmodule

// File: rtl/wcsel_fb_div.sv
module wcsel_fb_div #(
    parameter int FB_DIV_LOG2 = 9
) (
    input  logic vco_clk,
    input  logic rst_n,
    input  logic fb_short,
    output logic fb_wc
);
    localparam int MSB_FULL  = FB_DIV_LOG2 - 1;
    localparam int MSB_SHORT = FB_DIV_LOG2 - 2;

    logic [FB_DIV_LOG2-1:0] cnt_q;

    always_ff @(posedge vco_clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_q + 1'b1;
    end

    generate
        if (FB_DIV_LOG2 >= 2) begin : g_sel
            assign fb_wc = fb_short ? cnt_q[MSB_SHORT] : cnt_q[MSB_FULL];
        end else begin : g_min
            assign fb_wc = cnt_q[0] & ~fb_short;
        end
    endgenerate
endmodule

// File: rtl/wordclock_ref_sel.sv
module wordclock_ref_sel
    import wcsel_pkg::*;
#(
    parameter int FB_DIV_LOG2 = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    input  logic              xtal1_wc,
    input  logic              xtal2_wc,
    input  logic              ext_a_wc,
    input  logic              ext_b_wc,
    input  logic              vco_clk,
    output logic              pfd_ref,
    output logic              fb_wc,
    output logic              xtal_en
);
    src_e src;
    logic halve_en, fb_short, ref_raw, ref_rise;
    logic reserved_unused;

    assign reserved_unused = ^wr_data[CTRL_W-1:USED_W];

    wcsel_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_bits  (wr_data[USED_W-1:0]),
        .src      (src),
        .halve_en (halve_en),
        .fb_short (fb_short),
        .xtal_en  (xtal_en)
    );

    always_comb begin
        unique case (src)
            ST_XTAL1: ref_raw = xtal1_wc;
            ST_XTAL2: ref_raw = xtal2_wc;
            ST_EXT_A: ref_raw = ext_a_wc;
            ST_EXT_B: ref_raw = ext_b_wc;
            default:  ref_raw = xtal1_wc;
        endcase
    end

    wcsel_ref_path u_ref (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_raw  (ref_raw),
        .halve_en (halve_en),
        .ref_out  (pfd_ref),
        .ref_rise (ref_rise)
    );

    wcsel_fb_div #(.FB_DIV_LOG2(FB_DIV_LOG2)) u_fb (
        .vco_clk  (vco_clk),
        .rst_n    (rst_n),
        .fb_short (fb_short),
        .fb_wc    (fb_wc)
    );
endmodule

// File: rtl/wcsel_chk.sv
module wcsel_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [1:0] wr_sel,
    input logic       xtal_en,
    input logic       pfd_ref,
    input logic       halve_en,
    input logic       ref_rise
);
    AST_RST_XTAL_ON: assert property (@(posedge clk) !rst_n |-> xtal_en); // R1

    AST_XTAL_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (xtal_en == ($past(wr_sel) < 2'd2))); // R3

    AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(xtal_en)); // R7

    AST_HALF_ONLY_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (halve_en && $past(halve_en) && !$past(ref_rise)) |-> $stable(pfd_ref)); // R4
endmodule

bind wordclock_ref_sel wcsel_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_sel   (wr_data[1:0]),
    .xtal_en  (xtal_en),
    .pfd_ref  (pfd_ref),
    .halve_en (halve_en),
    .ref_rise (ref_rise)
);

// File: tb/wordclock_ref_sel_tb.sv
module wordclock_ref_sel_tb;
    logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, vco_clk = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [3:0] wc_in = 4'h0;
    logic pfd_ref, fb_wc, xtal_en;
    int checks = 0, fails = 0;

    always #2 clk = ~clk;

    wordclock_ref_sel #(.FB_DIV_LOG2(4)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .xtal1_wc(wc_in[0]), .xtal2_wc(wc_in[1]),
        .ext_a_wc(wc_in[2]), .ext_b_wc(wc_in[3]),
        .vco_clk(vco_clk), .pfd_ref(pfd_ref), .fb_wc(fb_wc), .xtal_en(xtal_en)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0; wc_in = 4'h0;
        wait_cyc(3); rst_n = 1'b1; wait_cyc(1);
    endtask

    task automatic write_ctrl(input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_data = d;
        @(negedge clk); wr_en = 1'b0; wr_data = 8'h00;
    endtask

    task automatic vco_pulses(input int n);
        repeat (n) begin vco_clk = 1'b1; #5; vco_clk = 1'b0; #5; end
    endtask

    task automatic test_reset();
        check("R1 xtal_en", xtal_en, 1'b1);
        check("R1 pfd_ref", pfd_ref, 1'b0);
        check("R1 fb_wc", fb_wc, 1'b0);
        wc_in = 4'b0001; wait_cyc(3);
        check("R1 crystal1 default", pfd_ref, 1'b1);
        wc_in = 4'h0; wait_cyc(3);
    endtask

    task automatic test_mux();
        for (int s = 0; s < 4; s++) begin
            write_ctrl(8'(s));
            check("R3 xtal_en after write", xtal_en, (s < 2));
            wc_in = 4'b0001 << s; wait_cyc(3);
            check("R2 selected high", pfd_ref, 1'b1);
            wc_in = ~(4'b0001 << s); wait_cyc(3);
            check("R2 others ignored", pfd_ref, 1'b0);
            wc_in = 4'h0; wait_cyc(2);
        end
    endtask

    task automatic test_reserved();
        write_ctrl(8'hF2);
        check("R5 xtal_en", xtal_en, 1'b0);
        wc_in = 4'b0100; wait_cyc(3);
        check("R5 pass-through kept", pfd_ref, 1'b1);
        wc_in = 4'b1011; wait_cyc(3);
        check("R5 source kept", pfd_ref, 1'b0);
        wc_in = 4'h0; wait_cyc(2);
    endtask

    task automatic test_no_write();
        @(negedge clk); wr_data = 8'h05;
        wait_cyc(4);
        check("R7 xtal_en held", xtal_en, 1'b0);
        wc_in = 4'b0100; wait_cyc(3);
        check("R7 source held", pfd_ref, 1'b1);
        wc_in = 4'h0; wr_data = 8'h00; wait_cyc(2);
    endtask

    task automatic test_halve();
        logic p;
        write_ctrl(8'h06);
        wait_cyc(3);
        p = pfd_ref;
        wc_in = 4'b0100; wait_cyc(3);
        check("R4 toggles on first rise", pfd_ref, ~p);
        wc_in = 4'h0; wait_cyc(3);
        check("R4 no change on fall", pfd_ref, ~p);
        wc_in = 4'b1000; wait_cyc(3);
        check("R4 unselected ignored", pfd_ref, ~p);
        wc_in = 4'b0100; wait_cyc(3);
        check("R4 toggles on second rise", pfd_ref, p);
        wc_in = 4'h0; wait_cyc(2);
    endtask

    task automatic test_fb();
        do_reset();
        vco_pulses(7);
        check("R6 full ratio low half", fb_wc, 1'b0);
        vco_pulses(1);
        check("R6 full ratio rises at 8", fb_wc, 1'b1);
        vco_pulses(7);
        check("R6 full ratio high half", fb_wc, 1'b1);
        vco_pulses(1);
        check("R6 full ratio falls at 16", fb_wc, 1'b0);
        do_reset();
        write_ctrl(8'h08);
        vco_pulses(3);
        check("R6 short ratio low half", fb_wc, 1'b0);
        vco_pulses(1);
        check("R6 short ratio rises at 4", fb_wc, 1'b1);
        vco_pulses(4);
        check("R6 short ratio falls at 8", fb_wc, 1'b0);
    endtask

    initial begin
        #200000;
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        wait_cyc(3); rst_n = 1'b1; wait_cyc(1);
        test_reset();
        test_mux();
        test_reserved();
        test_no_write();
        test_halve();
        test_fb();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule